// File: doc/BRIEF.md
# Random Number Generator Peripheral with Conditional Reset

This block is a memory-mapped random word source for a 32-bit register bus. Software enables generation, waits for the ready flag, and reads 32-bit words from a data register. An internal linear-feedback shift register stands in for the entropy source. Two test inputs inject faults: one raises a seed (noise-source) error and one raises a clock error.

A seed error stops generation and raises two status bits: a "current" bit and a sticky interrupt bit. A short transient is cleared by an internal auto-reset, which leaves only the sticky bit for software to clear. A persistent fault keeps the current bit set until software runs the conditional reset. Software writes the conditional-reset control bit to 1 and then to 0. The block then spends a fixed number of cycles resetting and clears the bit by itself. Configuration fields are captured only by the write that sets that bit, and a lock bit freezes all configuration until the next reset.

Register offsets (byte address on `reg_addr`): 0x00 control, 0x04 status, 0x08 data, 0x0C noise-source control, 0x10 health-test control. All other offsets read 0.

Top module: `rng_periph`

## Requirements
- R1: After reset every register reads 0, and so does any unmapped offset. A read access places its data on `reg_rdata` at the clock edge of the access, so the value is visible in the following cycle and holds until the next read.
- R2: Writing control bit 2 to 1 enables generation. Status bit 0 (ready) then asserts between STARTUP (32) and STARTUP+3 cycles after the enabling write. Writing control bit 2 to 0 clears ready on the next cycle.
- R3: Reading the data register while ready is set returns a nonzero word and clears ready. The next word is ready between G and G+3 cycles later, where G = WORD_GAP (4) shifted left by control bits 19:16. Two successive words differ.
- R4: Reading the data register while ready is clear, or while a seed error is current, returns 0. This value marks a late seed error.
- R5: A rising edge on `seed_err_inj` sets status bit 2 (current seed error) and status bit 6 (seed error flag). It also clears ready and stops generation.
- R6: The block runs a 16-cycle auto-reset after the rising edge. If `seed_err_inj` is low when that window ends, status bit 2 clears by itself, bit 6 stays set, and ready returns after the startup delay.
- R7: If `seed_err_inj` is still high when the auto-reset window ends, status bit 2 stays set, even after the input falls, until a conditional reset completes.
- R8: A control write with bit 30 set arms the conditional reset. A later control write with bit 30 clear starts it. Bit 30 reads 1 from the arming write until 16 cycles after the releasing write, then clears by itself. Completion clears status bit 2. Ready stays low while bit 30 reads 1.
- R9: Control bits 29:4 change only through a control write that also has bit 30 set. Any other control write updates only bit 2 and can set bit 31.
- R10: Once a control write sets bit 31 (lock), it stays set until reset. While it is set, control bits 29:4, the noise-source register and the health-test register ignore writes.
- R11: The noise-source register stores bits 17:0 and reads 0 in bits 31:18. The health-test register stores all 32 bits.
- R12: Writing 0 to status bit 5 or bit 6 clears that flag, and writing 1 leaves it unchanged. Status bits 0 to 2 ignore writes.
- R13: While control bit 5 is 0, a high `clk_err_inj` sets status bit 1 (current clock error, following the input with one cycle of delay) and the sticky status bit 5. While control bit 5 is 1, the input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| seed_err_inj | input | 1 | Test input: seed error source |
| clk_err_inj | input | 1 | Test input: clock error source |

## Verification
The assertions check five rules on every cycle:
- the lock bit never clears, and locked configuration, noise and health state never move;
- a rising seed-error input always raises both seed bits;
- ready is dropped whenever generation is disabled, a conditional reset is busy, or a seed error is current;
- masked clock-error detection keeps the current clock-error bit low.

The bench scenarios cover the rest:
- the startup and word-spacing windows, including the effect of the divider;
- the difference between the auto-recovered and the stuck seed error;
- the two-write conditional-reset handshake and its self-clearing timing;
- the zero word returned on a late seed error;
- configuration fields ignored on ordinary or locked writes.

// File: rtl/rng_pkg.sv
// Package: shared constants and types for the random number peripheral.
// Assumes a byte-addressed register map of five 32-bit registers.
package rng_pkg;

    localparam int unsigned AW      = 5;    // register address width
    localparam int unsigned DW      = 32;   // bus data width
    localparam int unsigned DIV_W   = 4;    // divider exponent width
    localparam int unsigned NOISE_W = 18;   // writable noise-control bits

    // register offsets
    localparam logic [AW-1:0] OFF_CTRL   = 5'h00;
    localparam logic [AW-1:0] OFF_STAT   = 5'h04;
    localparam logic [AW-1:0] OFF_DATA   = 5'h08;
    localparam logic [AW-1:0] OFF_NOISE  = 5'h0C;
    localparam logic [AW-1:0] OFF_HEALTH = 5'h10;

    // control bit positions
    localparam int unsigned CB_EN     = 2;
    localparam int unsigned CB_CEDOFF = 5;
    localparam int unsigned CB_DIV    = 16;
    localparam int unsigned CB_CRST   = 30;
    localparam int unsigned CB_LOCK   = 31;
    localparam int unsigned CFG_LO    = 4;
    localparam int unsigned CFG_HI    = 29;
    localparam int unsigned CFG_W     = CFG_HI - CFG_LO + 1;

    // status bit positions
    localparam int unsigned SB_RDY  = 0;
    localparam int unsigned SB_CCUR = 1;
    localparam int unsigned SB_SCUR = 2;
    localparam int unsigned SB_CFLG = 5;
    localparam int unsigned SB_SFLG = 6;

    // error status bundle
    typedef struct packed {
        logic seed_cur;
        logic seed_flg;
        logic clk_cur;
        logic clk_flg;
    } err_t;

    // conditional reset sequencer states
    typedef enum logic [1:0] {
        CR_IDLE  = 2'd0,
        CR_ARMED = 2'd1,
        CR_RUN   = 2'd2
    } crst_st_e;

endpackage

// File: rtl/rng_ctrl_regs.sv
// Control, noise-control and health-control registers plus the
// conditional-reset sequencer. Configuration is captured only by a control
// write carrying the conditional-reset bit; the lock bit is sticky until
// reset and freezes configuration, noise and health state.
// Assumes one-cycle write strobes decoded by the top.
module rng_ctrl_regs
    import rng_pkg::*;
#(
    parameter int unsigned          CRST_CYC   = 16,
    parameter logic [CFG_W-1:0]     CFG_RST    = '0,
    parameter logic [NOISE_W-1:0]   NOISE_RST  = '0,
    parameter logic [DW-1:0]        HEALTH_RST = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic                wr_noise,
    input  logic                wr_health,
    input  logic                w_en_bit,
    input  logic                w_crst_bit,
    input  logic                w_lock_bit,
    input  logic [CFG_W-1:0]    w_cfg,
    input  logic [DW-1:0]       w_data,
    output logic                gen_en,
    output logic                lock,
    output logic [CFG_W-1:0]    cfg,
    output logic                crst_busy,
    output logic                crst_done,
    output logic [NOISE_W-1:0]  noise,
    output logic [DW-1:0]       health
);

    localparam int unsigned CNT_W = $clog2(CRST_CYC + 1);

    crst_st_e           state;
    logic [CNT_W-1:0]   cnt;

    // Purpose: enable, lock and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
            lock   <= 1'b0;
            cfg    <= CFG_RST;
        end else if (wr_ctrl) begin
            gen_en <= w_en_bit;
            if (w_lock_bit)
                lock <= 1'b1;
            if (w_crst_bit && !lock)
                cfg <= w_cfg;
        end
    end

    // Purpose: noise and health register writes, blocked by the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            noise  <= NOISE_RST;
            health <= HEALTH_RST;
        end else begin
            if (wr_noise && !lock)
                noise <= w_data[NOISE_W-1:0];
            if (wr_health && !lock)
                health <= w_data;
        end
    end

    // Purpose: arm on bit set, run a fixed count after bit release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CR_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                CR_IDLE: begin
                    if (wr_ctrl && w_crst_bit)
                        state <= CR_ARMED;
                end
                CR_ARMED: begin
                    if (wr_ctrl && !w_crst_bit) begin
                        state <= CR_RUN;
                        cnt   <= CNT_W'(CRST_CYC);
                    end
                end
                CR_RUN: begin
                    if (cnt == CNT_W'(1))
                        state <= CR_IDLE;
                    else
                        cnt <= cnt - CNT_W'(1);
                end
                default: state <= CR_IDLE;
            endcase
        end
    end

    // Purpose: busy flag and completion pulse.
    always_comb begin
        crst_busy = (state != CR_IDLE);
        crst_done = (state == CR_RUN) && (cnt == CNT_W'(1));
    end

endmodule

// File: rtl/rng_gen.sv
// Word generator: a Galois shift register steps every cycle while running.
// A startup timer gates the first word, and a gap timer scaled by a
// power-of-two divider gates each later word. The held word is zero
// whenever no fresh word is ready. Assumes a nonzero seed.
module rng_gen
    import rng_pkg::*;
#(
    parameter int unsigned  STARTUP  = 32,
    parameter int unsigned  WORD_GAP = 4,
    parameter logic [DW-1:0] SEED    = 32'h1D87_2B41,
    parameter logic [DW-1:0] POLY    = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  div,
    input  logic              take,
    output logic              drdy,
    output logic [DW-1:0]     word
);

    localparam int unsigned GAP_MAX  = WORD_GAP << ((1 << DIV_W) - 1);
    localparam int unsigned WAIT_MAX = (GAP_MAX > STARTUP) ? GAP_MAX : STARTUP;
    localparam int unsigned TW       = $clog2(WAIT_MAX + 1);

    logic [DW-1:0] lfsr;
    logic [DW-1:0] lfsr_nx;
    logic [TW-1:0] tmr;
    logic [TW-1:0] gap;

    // Purpose: next shift register state and scaled word gap.
    always_comb begin
        lfsr_nx = lfsr[0] ? ((lfsr >> 1) ^ POLY) : (lfsr >> 1);
        gap     = TW'(WORD_GAP) << div;
    end

    // Purpose: advance the entropy model while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr <= SEED;
        else if (run)
            lfsr <= lfsr_nx;
    end

    // Purpose: startup / gap timing, ready flag and word hold.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            drdy <= 1'b0;
            word <= '0;
            tmr  <= TW'(STARTUP);
        end else if (take && drdy) begin
            drdy <= 1'b0;
            word <= '0;
            tmr  <= gap;
        end else if (!drdy) begin
            if (tmr == '0) begin
                drdy <= 1'b1;
                word <= lfsr;
            end else begin
                tmr <= tmr - TW'(1);
            end
        end
    end

endmodule

// File: rtl/rng_err.sv
// Error flags. A seed-error rising edge sets the current and sticky bits and
// starts an auto-reset window; the current bit clears at the window end only
// if the source has gone quiet, otherwise it waits for a conditional reset.
// Clock errors are tracked unless detection is masked.
// Sticky flags clear when written 0.
module rng_err
    import rng_pkg::*;
#(
    parameter int unsigned AUTO_CYC = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  seed_in,
    input  logic  clk_in,
    input  logic  ced_off,
    input  logic  wr_stat,
    input  logic  w_sflg,
    input  logic  w_cflg,
    input  logic  crst_done,
    output err_t  st
);

    localparam int unsigned AW_CNT = $clog2(AUTO_CYC + 1);

    logic              seed_q;
    logic              auto_run;
    logic [AW_CNT-1:0] acnt;
    logic              seed_rise;
    logic              clk_seen;

    // Purpose: edge detect and masked clock error.
    always_comb begin
        seed_rise = seed_in && !seed_q;
        clk_seen  = clk_in && !ced_off;
    end

    // Purpose: seed error flags and auto-reset window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q      <= 1'b0;
            auto_run    <= 1'b0;
            acnt        <= '0;
            st.seed_cur <= 1'b0;
            st.seed_flg <= 1'b0;
        end else begin
            seed_q <= seed_in;
            if (seed_rise) begin
                st.seed_cur <= 1'b1;
                st.seed_flg <= 1'b1;
                auto_run    <= 1'b1;
                acnt        <= AW_CNT'(AUTO_CYC);
            end else begin
                if (auto_run) begin
                    if (acnt == AW_CNT'(1)) begin
                        auto_run <= 1'b0;
                        if (!seed_in)
                            st.seed_cur <= 1'b0;
                    end else begin
                        acnt <= acnt - AW_CNT'(1);
                    end
                end
                if (crst_done)
                    st.seed_cur <= 1'b0;
                if (wr_stat && !w_sflg)
                    st.seed_flg <= 1'b0;
            end
        end
    end

    // Purpose: clock error current and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.clk_cur <= 1'b0;
            st.clk_flg <= 1'b0;
        end else begin
            st.clk_cur <= clk_seen;
            if (clk_seen && !st.clk_cur)
                st.clk_flg <= 1'b1;
            else if (wr_stat && !w_cflg)
                st.clk_flg <= 1'b0;
        end
    end

endmodule

// File: rtl/rng_periph.sv
// Top of the random number peripheral: bus decode, read mux with a
// registered read port, and wiring of control, generator and error logic.
// Assumes single-cycle accesses; reads take effect at the access edge.
module rng_periph
    import rng_pkg::*;
#(
    parameter int unsigned         STARTUP    = 32,
    parameter int unsigned         WORD_GAP   = 4,
    parameter int unsigned         CRST_CYC   = 16,
    parameter logic [CFG_W-1:0]    CFG_RST    = '0,
    parameter logic [NOISE_W-1:0]  NOISE_RST  = '0,
    parameter logic [DW-1:0]       HEALTH_RST = '0,
    parameter logic [DW-1:0]       SEED       = 32'h1D87_2B41
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_en,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           seed_err_inj,
    input  logic           clk_err_inj
);

    localparam int unsigned DIV_OFS  = CB_DIV - CFG_LO;
    localparam int unsigned CED_OFS  = CB_CEDOFF - CFG_LO;

    logic                wr, rd;
    logic                wr_ctrl, wr_stat, wr_noise, wr_health, take;
    logic                gen_en, lock, crst_busy, crst_done;
    logic [CFG_W-1:0]    cfg_q;
    logic [NOISE_W-1:0]  noise_q;
    logic [DW-1:0]       health_q;
    logic                drdy;
    logic [DW-1:0]       word;
    logic                run;
    logic                ced_off;
    logic [DIV_W-1:0]    div;
    err_t                err_st;
    logic [DW-1:0]       ctrl_view, stat_view, rd_mux;

    // Purpose: access decode.
    always_comb begin
        wr        = reg_en && reg_we;
        rd        = reg_en && !reg_we;
        wr_ctrl   = wr && (reg_addr == OFF_CTRL);
        wr_stat   = wr && (reg_addr == OFF_STAT);
        wr_noise  = wr && (reg_addr == OFF_NOISE);
        wr_health = wr && (reg_addr == OFF_HEALTH);
        take      = rd && (reg_addr == OFF_DATA);
    end

    // Purpose: derived controls for generator and error logic.
    always_comb begin
        ced_off = cfg_q[CED_OFS];
        div     = cfg_q[DIV_OFS +: DIV_W];
        run     = gen_en && !crst_busy && !err_st.seed_cur;
    end

    rng_ctrl_regs #(
        .CRST_CYC   (CRST_CYC),
        .CFG_RST    (CFG_RST),
        .NOISE_RST  (NOISE_RST),
        .HEALTH_RST (HEALTH_RST)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_noise   (wr_noise),
        .wr_health  (wr_health),
        .w_en_bit   (reg_wdata[CB_EN]),
        .w_crst_bit (reg_wdata[CB_CRST]),
        .w_lock_bit (reg_wdata[CB_LOCK]),
        .w_cfg      (reg_wdata[CFG_HI:CFG_LO]),
        .w_data     (reg_wdata),
        .gen_en     (gen_en),
        .lock       (lock),
        .cfg        (cfg_q),
        .crst_busy  (crst_busy),
        .crst_done  (crst_done),
        .noise      (noise_q),
        .health     (health_q)
    );

    rng_gen #(
        .STARTUP  (STARTUP),
        .WORD_GAP (WORD_GAP),
        .SEED     (SEED)
    ) gen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div),
        .take  (take),
        .drdy  (drdy),
        .word  (word)
    );

    rng_err #(
        .AUTO_CYC (CRST_CYC)
    ) err_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_in   (seed_err_inj),
        .clk_in    (clk_err_inj),
        .ced_off   (ced_off),
        .wr_stat   (wr_stat),
        .w_sflg    (reg_wdata[SB_SFLG]),
        .w_cflg    (reg_wdata[SB_CFLG]),
        .crst_done (crst_done),
        .st        (err_st)
    );

    // Purpose: assemble register views and select the read source.
    always_comb begin
        ctrl_view = {lock, crst_busy, cfg_q, 1'b0, gen_en, 2'b00};
        stat_view = '0;
        stat_view[SB_RDY]  = drdy;
        stat_view[SB_CCUR] = err_st.clk_cur;
        stat_view[SB_SCUR] = err_st.seed_cur;
        stat_view[SB_CFLG] = err_st.clk_flg;
        stat_view[SB_SFLG] = err_st.seed_flg;
        case (reg_addr)
            OFF_CTRL:   rd_mux = ctrl_view;
            OFF_STAT:   rd_mux = stat_view;
            OFF_DATA:   rd_mux = word;
            OFF_NOISE:  rd_mux = {{(DW-NOISE_W){1'b0}}, noise_q};
            OFF_HEALTH: rd_mux = health_q;
            default:    rd_mux = '0;
        endcase
    end

    // Purpose: registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (rd)
            reg_rdata <= rd_mux;
    end

endmodule

// File: rtl/rng_periph_chk.sv
// Checker for rng_periph: cycle-level properties on lock, seed error
// flags, ready gating and clock error masking. Bound into the top below.
module rng_periph_chk
    import rng_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                seed_err_inj,
    input logic                gen_en,
    input logic                lock,
    input logic                crst_busy,
    input logic                drdy,
    input logic                ced_off,
    input err_t                st,
    input logic [CFG_W-1:0]    cfg,
    input logic [NOISE_W-1:0]  noise,
    input logic [DW-1:0]       health
);

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R10
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(cfg) && $stable(noise) && $stable(health)));

    // R5
    seed_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seed_err_inj) |=> (st.seed_cur && st.seed_flg));

    // R8
    halt_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crst_busy || st.seed_cur || !gen_en) |=> !drdy);

    // R13
    ced_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ced_off && $past(ced_off)) |-> !st.clk_cur);

endmodule

bind rng_periph rng_periph_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .seed_err_inj (seed_err_inj),
    .gen_en       (gen_en),
    .lock         (lock),
    .crst_busy    (crst_busy),
    .drdy         (drdy),
    .ced_off      (ced_off),
    .st           (err_st),
    .cfg          (cfg_q),
    .noise        (noise_q),
    .health       (health_q)
);

// File: tb/rng_periph_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read values, a monitor
// pops and compares them when the read data appears.
module rng_periph_tb_top;
    import rng_pkg::*;

    localparam int STARTUP = 32;
    localparam int GAP     = 4;
    localparam int CRST    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_en = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          seed_inj = 1'b0;
    logic          clk_inj = 1'b0;

    always #2.5 clk = ~clk;

    rng_periph dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_en       (reg_en),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .seed_err_inj (seed_inj),
        .clk_err_inj  (clk_inj)
    );

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        bit          chk;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    logic  rd_fire = 1'b0;

    // monitor: marks read accesses, compares at the following negedge
    always @(posedge clk) rd_fire <= reg_en & ~reg_we;

    always @(negedge clk) begin
        item_t it;
        if (rd_fire) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R1 unexpected read response: got %h expected none", reg_rdata);
            end else begin
                it = sb_q.pop_front();
                if (it.chk) begin
                    n_cmp++;
                    if ((reg_rdata & it.mask) !== (it.exp & it.mask)) begin
                        n_bad++;
                        $display("FAIL %s: got %h expected %h", it.tag,
                                 reg_rdata & it.mask, it.exp & it.mask);
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] e,
                             input logic [31:0] m, input string tag);
        item_t it;
        it.exp = e; it.mask = m; it.chk = 1'b1; it.tag = tag;
        sb_q.push_back(it);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [31:0] v);
        item_t it;
        it.exp = '0; it.mask = '0; it.chk = 1'b0; it.tag = "";
        sb_q.push_back(it);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        #1 v = reg_rdata;
    endtask

    // polls one bit; k is the index of the first read showing val, 0 if none
    task automatic poll(input logic [AW-1:0] a, input int bitpos, input logic val,
                        input int limit, output int k);
        logic [31:0] v;
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            peek(a, v);
            if (v[bitpos] == val) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        logic [31:0] d1, d2, v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and unmapped offset
        expect_rd(OFF_CTRL,   32'h0, 32'hFFFF_FFFF, "R1 ctrl reset");
        expect_rd(OFF_STAT,   32'h0, 32'hFFFF_FFFF, "R1 status reset");
        expect_rd(OFF_DATA,   32'h0, 32'hFFFF_FFFF, "R1 data reset");
        expect_rd(OFF_NOISE,  32'h0, 32'hFFFF_FFFF, "R1 noise reset");
        expect_rd(OFF_HEALTH, 32'h0, 32'hFFFF_FFFF, "R1 health reset");
        expect_rd(5'h14,      32'h0, 32'hFFFF_FFFF, "R1 unmapped");

        // R11 register widths
        bus_wr(OFF_NOISE, 32'hFFFF_FFFF);
        expect_rd(OFF_NOISE, 32'h0003_FFFF, 32'hFFFF_FFFF, "R11 noise width");
        bus_wr(OFF_HEALTH, 32'hA5A5_1234);
        expect_rd(OFF_HEALTH, 32'hA5A5_1234, 32'hFFFF_FFFF, "R11 health width");

        // R13 clock error with detection on, R12 flag clearing
        clk_inj = 1'b1; idle(3);
        expect_rd(OFF_STAT, 32'h22, 32'h22, "R13 clock error raised");
        clk_inj = 1'b0; idle(3);
        expect_rd(OFF_STAT, 32'h20, 32'h22, "R13 clock error sticky");
        bus_wr(OFF_STAT, 32'h60);
        expect_rd(OFF_STAT, 32'h20, 32'h20, "R12 write 1 keeps flag");
        bus_wr(OFF_STAT, 32'h40);
        expect_rd(OFF_STAT, 32'h00, 32'h20, "R12 write 0 clears flag");
        bus_wr(OFF_STAT, 32'h07);
        expect_rd(OFF_STAT, 32'h00, 32'h07, "R12 low bits read-only");

        // R2 startup delay
        bus_wr(OFF_CTRL, 32'h4);
        poll(OFF_STAT, SB_RDY, 1'b1, 80, k);
        check(k >= STARTUP && k <= STARTUP + 3, "R2 startup window", k, STARTUP + 2);

        // R3 data read and word gap, divider 0
        peek(OFF_DATA, d1);
        check(d1 != 0, "R3 first word nonzero", int'(d1), 1);
        peek(OFF_STAT, v);
        check(v[0] == 1'b0, "R3 read clears ready", int'(v[0]), 0);
        poll(OFF_STAT, SB_RDY, 1'b1, 40, k);
        check(k >= GAP && k <= GAP + 3, "R3 gap window div0", k, GAP + 1);
        peek(OFF_DATA, d2);
        check(d2 != 0 && d2 != d1, "R3 second word differs", int'(d2), int'(d1));

        // R9 config ignored without the reset bit
        bus_wr(OFF_CTRL, 32'h0002_0024);
        expect_rd(OFF_CTRL, 32'h0000_0004, 32'hFFFF_FFFF, "R9 plain write ignores cfg");

        // R8 conditional reset with config capture, divider 2
        bus_wr(OFF_CTRL, 32'h4002_0004);
        expect_rd(OFF_CTRL, 32'h4002_0004, 32'hFFFF_FFFF, "R9 cfg captured when armed");
        expect_rd(OFF_STAT, 32'h0, 32'h1, "R8 no ready while armed");
        bus_wr(OFF_CTRL, 32'h0000_0004);
        poll(OFF_CTRL, CB_CRST, 1'b0, 40, k);
        check(k >= CRST && k <= CRST + 3, "R8 self-clear window", k, CRST + 1);
        expect_rd(OFF_CTRL, 32'h0002_0004, 32'hFFFF_FFFF, "R9 cfg kept by release write");
        poll(OFF_STAT, SB_RDY, 1'b1, 80, k);
        check(k > 0, "R2 ready after conditional reset", k, 1);
        peek(OFF_DATA, d1);
        poll(OFF_STAT, SB_RDY, 1'b1, 80, k);
        check(k >= (GAP << 2) && k <= (GAP << 2) + 3, "R3 gap window div2", k, (GAP << 2) + 2);

        // R5 R4 R6 transient seed error with auto-reset
        seed_inj = 1'b1; idle(2); seed_inj = 1'b0;
        expect_rd(OFF_STAT, 32'h44, 32'h45, "R5 seed flags set, ready low");
        expect_rd(OFF_DATA, 32'h0, 32'hFFFF_FFFF, "R4 late seed error reads 0");
        idle(30);
        expect_rd(OFF_STAT, 32'h40, 32'h44, "R6 auto-reset clears current bit");
        poll(OFF_STAT, SB_RDY, 1'b1, 80, k);
        check(k > 0, "R6 ready returns after auto-reset", k, 1);
        bus_wr(OFF_STAT, 32'h0);
        expect_rd(OFF_STAT, 32'h00, 32'h66, "R12 seed flag cleared by 0");

        // R7 stuck seed error needs conditional reset
        seed_inj = 1'b1; idle(25); seed_inj = 1'b0; idle(5);
        expect_rd(OFF_STAT, 32'h04, 32'h05, "R7 current bit stays set");
        expect_rd(OFF_DATA, 32'h0, 32'hFFFF_FFFF, "R4 data 0 while stuck");
        bus_wr(OFF_CTRL, 32'h4002_0004);
        bus_wr(OFF_CTRL, 32'h0000_0004);
        idle(25);
        expect_rd(OFF_STAT, 32'h40, 32'h44, "R8 reset clears current bit only");
        bus_wr(OFF_STAT, 32'h0);

        // R13 detection masked by control bit 5
        bus_wr(OFF_CTRL, 32'h4002_0024);
        bus_wr(OFF_CTRL, 32'h0000_0004);
        idle(20);
        clk_inj = 1'b1; idle(4);
        expect_rd(OFF_STAT, 32'h00, 32'h22, "R13 masked clock error ignored");
        clk_inj = 1'b0;

        // R10 lock
        bus_wr(OFF_CTRL, 32'h8000_0004);
        expect_rd(OFF_CTRL, 32'h8002_0024, 32'hFFFF_FFFF, "R10 lock set");
        bus_wr(OFF_NOISE, 32'h1);
        expect_rd(OFF_NOISE, 32'h0003_FFFF, 32'hFFFF_FFFF, "R10 noise frozen");
        bus_wr(OFF_HEALTH, 32'h0);
        expect_rd(OFF_HEALTH, 32'hA5A5_1234, 32'hFFFF_FFFF, "R10 health frozen");
        bus_wr(OFF_CTRL, 32'h4000_0004);
        expect_rd(OFF_CTRL, 32'hC002_0024, 32'hFFFF_FFFF, "R10 cfg frozen while armed");
        bus_wr(OFF_CTRL, 32'h0000_0004);
        idle(20);
        expect_rd(OFF_CTRL, 32'h8002_0024, 32'hFFFF_FFFF, "R10 cfg frozen after reset");
        bus_wr(OFF_CTRL, 32'h0);
        expect_rd(OFF_CTRL, 32'h8002_0020, 32'hFFFF_FFFF, "R10 lock sticky");
        expect_rd(OFF_STAT, 32'h0, 32'h1, "R2 disable drops ready");

        idle(3);
        done = 1;
        summary();
        $finish;
    end

endmodule